// File: doc/BRIEF.md
# Guarded Scaled-Index Halfword Load Unit

This block is a pipelined load path that fetches an unsigned 16-bit quantity from a byte-addressed data memory and hands it back zero-extended to 32 bits. The effective address is formed from a base operand plus twice an index operand, so the index counts halfwords. Each operation carries a guard word. Only its least significant bit matters, and when that bit is clear the operation leaves no trace: no writeback strobe and no side-effect strobe.

The byte order is picked per operation by a mode bit. Results come back on a writeback interface with the destination tag exactly three cycles after issue. One operation can be accepted every cycle, and results leave in issue order. A misaligned address or an address inside the memory-mapped I/O window does not trap. The operation completes, the returned data is unspecified, and flags travel with the result so the consumer can tell. The memory is an internal byte RAM, split into even and odd banks, with its own preload write port. A single-cycle strobe marks guarded-true accesses that fall in a cacheable address range.

Top module: `hw_scaled_load`

## Requirements
- R1: The effective address EA is `iss_base + 2*iss_index` in 32-bit arithmetic, wrapping modulo 2^32. The RAM is indexed by the low RAM_AW bits of EA and of EA+1, so base 0xD04 with index 0xFFFFFFFE addresses 0xD00.
- R2: With `iss_little` = 1, `wb_data[7:0]` is the byte at EA and `wb_data[15:8]` is the byte at EA+1.
- R3: With `iss_little` = 0, `wb_data[15:8]` is the byte at EA and `wb_data[7:0]` is the byte at EA+1. With bytes 0x84 at 0xD00 and 0x33 at 0xD01 the result is 0x00008433.
- R4: Whenever `wb_valid` is 1, `wb_data[31:16]` is zero.
- R5: Only bit 0 of `iss_guard` is used. An operation whose guard bit 0 is 0 never raises `wb_valid` or `cache_touch`.
- R6: A guarded-true operation issued in cycle n (iss_valid = 1, sampled at the rising edge that ends cycle n) produces `wb_valid` = 1 with its own tag in cycle n+3. One operation can issue per cycle, and results keep issue order.
- R7: `wb_misaligned` equals EA bit 0. A misaligned operation still completes with `wb_valid` and its tag, and its data is unspecified.
- R8: `wb_io_window` is 1 exactly when IO_BASE <= EA < IO_BASE+IO_SIZE. The data for such an operation is unspecified.
- R9: `cache_touch` is high for exactly the result cycle of a guarded-true operation with CACHE_LO <= EA < CACHE_HI, and is low otherwise.
- R10: The synchronous reset `rst` discards every operation in flight. `wb_valid` and `cache_touch` are 0 while `rst` is high and stay 0 afterwards until a new operation arrives.
- R11: When `pl_we` = 1, the rising edge writes `pl_data` into the RAM byte at `pl_addr`. Later loads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Operation issued this cycle |
| iss_base | input | 32 | Base operand |
| iss_index | input | 32 | Halfword index operand |
| iss_guard | input | 32 | Guard word, bit 0 predicates the operation |
| iss_little | input | 1 | Byte order: 1 little-endian, 0 big-endian |
| iss_tag | input | TAG_W | Destination tag |
| pl_we | input | 1 | Preload write enable |
| pl_addr | input | RAM_AW | Preload byte address |
| pl_data | input | 8 | Preload byte |
| wb_valid | output | 1 | Writeback strobe |
| wb_tag | output | TAG_W | Destination tag of the result |
| wb_data | output | 32 | Zero-extended halfword |
| wb_misaligned | output | 1 | EA was odd, data unspecified |
| wb_io_window | output | 1 | EA in I/O window, data unspecified |
| cache_touch | output | 1 | Cacheable-access side-effect strobe |

## Verification
A stage-valid bit that sticks or drops shows up as an extra or missing `wb_valid` exactly three cycles after the matching issue slot. A tag or guard bit that slips out of step with its stage shows up as a wrong `wb_tag` on the very next result. A wrong bank select or a wrong byte-order mux shows up as swapped or neighbouring bytes on the first aligned load of the affected order. A flag computed from the wrong address appears on the same result cycle as a mismatched `wb_misaligned`, `wb_io_window` or `cache_touch`. Because operations are issued back to back with distinct tags, a pipeline that mixes up stages is caught within four cycles.

// File: rtl/hwld_pkg.sv
package hwld_pkg;

  typedef enum logic {
    ORD_BIG    = 1'b0,
    ORD_LITTLE = 1'b1
  } byte_order_e;

  // Control word that travels with each operation down the pipe
  typedef struct packed {
    logic        live;       // issued and guard bit set
    byte_order_e order;
    logic        misal;      // EA bit 0, also selects the bank of the low byte
    logic        io_hit;
    logic        cache_hit;
  } op_ctl_t;

  function automatic logic [31:0] scaled_addr(input logic [31:0] base,
                                              input logic [31:0] idx);
    return base + {idx[30:0], 1'b0};
  endfunction

  // Unsigned window test without overflow: lo <= a < lo+size
  function automatic logic in_window(input logic [31:0] a,
                                     input logic [31:0] lo,
                                     input logic [31:0] size);
    return (a - lo) < size;
  endfunction

endpackage

// File: rtl/hwld_agen.sv
module hwld_agen
  import hwld_pkg::*;
#(
  parameter int          RAM_AW   = 12,
  parameter int          TAG_W    = 5,
  parameter logic [31:0] IO_BASE  = 32'h0000_0F00,
  parameter logic [31:0] IO_SIZE  = 32'h0000_0100,
  parameter logic [31:0] CACHE_LO = 32'h0000_0800,
  parameter logic [31:0] CACHE_HI = 32'h0000_0E00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [31:0]       iss_base,
  input  logic [31:0]       iss_index,
  input  logic              iss_guard_lsb,
  input  logic              iss_little,
  input  logic [TAG_W-1:0]  iss_tag,
  output op_ctl_t           ctl_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic [RAM_AW-1:0] ea_q
);

  localparam logic [31:0] CACHE_SIZE = CACHE_HI - CACHE_LO;

  logic [31:0] ea;
  op_ctl_t     ctl_d;

  always_comb begin
    ea              = scaled_addr(iss_base, iss_index);
    ctl_d.live      = iss_valid & iss_guard_lsb;
    ctl_d.order     = iss_little ? ORD_LITTLE : ORD_BIG;
    ctl_d.misal     = ea[0];
    ctl_d.io_hit    = in_window(ea, IO_BASE, IO_SIZE);
    ctl_d.cache_hit = in_window(ea, CACHE_LO, CACHE_SIZE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
    tag_q <= iss_tag;
    ea_q  <= ea[RAM_AW-1:0];
  end

  logic ea_unused;
  assign ea_unused = ^ea[31:RAM_AW];

endmodule

// File: rtl/hwld_byte_banks.sv
module hwld_byte_banks #(
  parameter int RAM_AW = 12
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [RAM_AW-1:0] rd_addr,
  input  logic              wr_en,
  input  logic [RAM_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        even_q,
  output logic [7:0]        odd_q
);

  localparam int BANK_AW    = RAM_AW - 1;
  localparam int BANK_DEPTH = 1 << BANK_AW;

  logic [RAM_AW-1:0]  nxt_addr;
  logic [BANK_AW-1:0] bank_idx [2];

  // The two bytes of a halfword always sit in opposite banks, even when EA is odd
  always_comb begin
    nxt_addr    = rd_addr + RAM_AW'(1);
    bank_idx[0] = rd_addr[0] ? nxt_addr[RAM_AW-1:1] : rd_addr[RAM_AW-1:1];
    bank_idx[1] = rd_addr[0] ? rd_addr[RAM_AW-1:1]  : nxt_addr[RAM_AW-1:1];
  end

  logic [7:0] bank_q [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0] mem [BANK_DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_addr[0] == 1'(b))) begin
        mem[wr_addr[RAM_AW-1:1]] <= wr_data;
      end
      if (rd_en) begin
        bank_q[b] <= mem[bank_idx[b]];
      end
    end
  end

  assign even_q = bank_q[0];
  assign odd_q  = bank_q[1];

endmodule

// File: rtl/hwld_align.sv
module hwld_align
  import hwld_pkg::*;
(
  input  logic        clk,
  input  logic        lo_odd,
  input  byte_order_e order,
  input  logic [7:0]  even_b,
  input  logic [7:0]  odd_b,
  output logic [31:0] data_q
);

  logic [7:0]  at_ea;
  logic [7:0]  at_ea1;
  logic [31:0] data_d;

  always_comb begin
    at_ea  = lo_odd ? odd_b  : even_b;
    at_ea1 = lo_odd ? even_b : odd_b;
    if (order == ORD_LITTLE) begin
      data_d = {16'h0000, at_ea1, at_ea};
    end else begin
      data_d = {16'h0000, at_ea, at_ea1};
    end
  end

  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

endmodule

// File: rtl/hw_scaled_load.sv
module hw_scaled_load
  import hwld_pkg::*;
#(
  parameter int          RAM_AW   = 12,
  parameter int          TAG_W    = 5,
  parameter logic [31:0] IO_BASE  = 32'h0000_0F00,
  parameter logic [31:0] IO_SIZE  = 32'h0000_0100,
  parameter logic [31:0] CACHE_LO = 32'h0000_0800,
  parameter logic [31:0] CACHE_HI = 32'h0000_0E00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [31:0]       iss_base,
  input  logic [31:0]       iss_index,
  input  logic [31:0]       iss_guard,
  input  logic              iss_little,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              pl_we,
  input  logic [RAM_AW-1:0] pl_addr,
  input  logic [7:0]        pl_data,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [31:0]       wb_data,
  output logic              wb_misaligned,
  output logic              wb_io_window,
  output logic              cache_touch
);

  // Stage 1: address generation and flags
  op_ctl_t           s1_ctl;
  logic [TAG_W-1:0]  s1_tag;
  logic [RAM_AW-1:0] s1_ea;

  hwld_agen #(
    .RAM_AW  (RAM_AW),
    .TAG_W   (TAG_W),
    .IO_BASE (IO_BASE),
    .IO_SIZE (IO_SIZE),
    .CACHE_LO(CACHE_LO),
    .CACHE_HI(CACHE_HI)
  ) u_agen (
    .clk          (clk),
    .rst          (rst),
    .iss_valid    (iss_valid),
    .iss_base     (iss_base),
    .iss_index    (iss_index),
    .iss_guard_lsb(iss_guard[0]),
    .iss_little   (iss_little),
    .iss_tag      (iss_tag),
    .ctl_q        (s1_ctl),
    .tag_q        (s1_tag),
    .ea_q         (s1_ea)
  );

  logic guard_unused;
  assign guard_unused = ^iss_guard[31:1];

  // Stage 2: bank reads, enabled only for live operations
  logic [7:0] even_b;
  logic [7:0] odd_b;

  hwld_byte_banks #(
    .RAM_AW(RAM_AW)
  ) u_banks (
    .clk    (clk),
    .rd_en  (s1_ctl.live),
    .rd_addr(s1_ea),
    .wr_en  (pl_we),
    .wr_addr(pl_addr),
    .wr_data(pl_data),
    .even_q (even_b),
    .odd_q  (odd_b)
  );

  op_ctl_t          s2_ctl;
  logic [TAG_W-1:0] s2_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_ctl <= '0;
    end else begin
      s2_ctl <= s1_ctl;
    end
    s2_tag <= s1_tag;
  end

  // Stage 3: byte steering and registered writeback
  hwld_align u_align (
    .clk   (clk),
    .lo_odd(s2_ctl.misal),
    .order (s2_ctl.order),
    .even_b(even_b),
    .odd_b (odd_b),
    .data_q(wb_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      cache_touch <= 1'b0;
    end else begin
      wb_valid    <= s2_ctl.live;
      cache_touch <= s2_ctl.live & s2_ctl.cache_hit;
    end
    wb_tag        <= s2_tag;
    wb_misaligned <= s2_ctl.misal;
    wb_io_window  <= s2_ctl.io_hit;
  end

endmodule

// File: rtl/hwld_checker.sv
module hwld_checker #(
  parameter int TAG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             iss_valid,
  input logic             iss_guard_lsb,
  input logic             iss_base_lsb,
  input logic [TAG_W-1:0] iss_tag,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag,
  input logic [15:0]      wb_hi,
  input logic             wb_misaligned,
  input logic             cache_touch
);

  // Edges seen since reset was released, saturating at 3
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= 2'd0;
    end else if (since_rst != 2'd3) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  AST_RESULT_AFTER_THREE: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(iss_valid & iss_guard_lsb, 3)) |-> wb_valid); // R6

  AST_TAG_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && $past(iss_valid & iss_guard_lsb, 3)) |-> (wb_tag == $past(iss_tag, 3))); // R6

  AST_NO_WB_WHEN_FALSE: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && !$past(iss_valid & iss_guard_lsb, 3)) |-> !wb_valid); // R5

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_hi == 16'h0000)); // R4

  AST_CACHE_NEEDS_RESULT: assert property (@(posedge clk) disable iff (rst)
    cache_touch |-> wb_valid); // R9

  AST_MISALIGN_FLAG: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && wb_valid) |-> (wb_misaligned == $past(iss_base_lsb, 3))); // R7

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 2'd3) |-> (!wb_valid && !cache_touch)); // R10

endmodule

bind hw_scaled_load hwld_checker #(.TAG_W(TAG_W)) u_hwld_checker (
  .clk          (clk),
  .rst          (rst),
  .iss_valid    (iss_valid),
  .iss_guard_lsb(iss_guard[0]),
  .iss_base_lsb (iss_base[0]),
  .iss_tag      (iss_tag),
  .wb_valid     (wb_valid),
  .wb_tag       (wb_tag),
  .wb_hi        (wb_data[31:16]),
  .wb_misaligned(wb_misaligned),
  .cache_touch  (cache_touch)
);

// File: tb/test_hw_scaled_load.sv
`timescale 1ns/1ps
module test_hw_scaled_load;

  localparam int          RAM_AW   = 12;
  localparam int          TAG_W    = 5;
  localparam int          MEM_N    = 1 << RAM_AW;
  localparam logic [31:0] IO_BASE  = 32'h0000_0F00;
  localparam logic [31:0] IO_SIZE  = 32'h0000_0100;
  localparam logic [31:0] CACHE_LO = 32'h0000_0800;
  localparam logic [31:0] CACHE_HI = 32'h0000_0E00;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              iss_valid = 1'b0;
  logic [31:0]       iss_base = '0;
  logic [31:0]       iss_index = '0;
  logic [31:0]       iss_guard = '0;
  logic              iss_little = 1'b0;
  logic [TAG_W-1:0]  iss_tag = '0;
  logic              pl_we = 1'b0;
  logic [RAM_AW-1:0] pl_addr = '0;
  logic [7:0]        pl_data = '0;
  logic              wb_valid;
  logic [TAG_W-1:0]  wb_tag;
  logic [31:0]       wb_data;
  logic              wb_misaligned;
  logic              wb_io_window;
  logic              cache_touch;

  always #2.5 clk = ~clk;

  hw_scaled_load #(
    .RAM_AW(RAM_AW), .TAG_W(TAG_W), .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE),
    .CACHE_LO(CACHE_LO), .CACHE_HI(CACHE_HI)
  ) i_hw_scaled_load (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_base(iss_base),
    .iss_index(iss_index), .iss_guard(iss_guard), .iss_little(iss_little),
    .iss_tag(iss_tag), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .wb_misaligned(wb_misaligned), .wb_io_window(wb_io_window),
    .cache_touch(cache_touch)
  );

  int compared = 0;
  int mismatched = 0;
  logic [7:0] ref_mem [MEM_N];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_data(input logic [31:0] ea, input logic little);
    logic [7:0] b_ea;
    logic [7:0] b_ea1;
    b_ea  = ref_mem[ea[RAM_AW-1:0]];
    b_ea1 = ref_mem[RAM_AW'(ea[RAM_AW-1:0] + 1)];
    return little ? {16'h0, b_ea1, b_ea} : {16'h0, b_ea, b_ea1};
  endfunction

  function automatic logic inside_range(input logic [31:0] a, input logic [31:0] lo,
                                        input logic [31:0] hi_excl);
    return (a >= lo) && (a < hi_excl);
  endfunction

  typedef struct packed {
    logic [31:0] base;
    logic [31:0] idx;
    logic [31:0] guard;
    logic        little;
  } vec_t;

  // Stimulus; expected results follow from the requirements via the bench model
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0D00, 32'h0000_0001, 32'h0000_0001, 1'b0}, // EA D02 big -> 2211
    '{32'h0000_0D04, 32'hFFFF_FFFE, 32'h0000_0000, 1'b0}, // guard false
    '{32'h0000_0D04, 32'hFFFF_FFFE, 32'h0000_0001, 1'b0}, // EA D00 big -> 8433
    '{32'h0000_0D04, 32'hFFFF_FFFE, 32'h0000_0001, 1'b1}, // EA D00 little -> 3384
    '{32'h0000_0100, 32'h0000_0010, 32'h0000_0003, 1'b1}, // EA 120, not cacheable
    '{32'h0000_0D01, 32'h0000_0001, 32'h0000_0001, 1'b0}, // EA D03 misaligned
    '{32'h0000_0F10, 32'h0000_0000, 32'h0000_0001, 1'b1}, // I/O window
    '{32'h0000_0200, 32'h0000_0000, 32'hFFFF_FFFE, 1'b1}, // bit 0 clear, rest set
    '{32'hFFFF_FFF0, 32'h8000_0010, 32'h0000_0001, 1'b1}, // wraps to EA 0x10
    '{32'h0000_07FE, 32'h0000_0001, 32'h0000_0001, 1'b0}, // EA 800 cache low edge
    '{32'h0000_0DFE, 32'h0000_0000, 32'h0000_0001, 1'b1}, // EA DFE last cacheable
    '{32'h0000_0E00, 32'h0000_0000, 32'h0000_0001, 1'b0}  // EA E00 past cache range
  };

  task automatic check_vec(input int i);
    logic [31:0] ea;
    logic        g;
    ea = VECS[i].base + VECS[i].idx * 32'd2;
    g  = VECS[i].guard[0];
    chk($sformatf("R5 wb_valid vec%0d", i), {31'h0, wb_valid}, {31'h0, g});
    chk($sformatf("R9 cache_touch vec%0d", i), {31'h0, cache_touch},
        {31'h0, g & inside_range(ea, CACHE_LO, CACHE_HI)});
    if (g) begin
      chk($sformatf("R6 tag vec%0d", i), 32'(wb_tag), 32'(i));
      chk($sformatf("R7 misaligned vec%0d", i), {31'h0, wb_misaligned}, {31'h0, ea[0]});
      chk($sformatf("R8 io flag vec%0d", i), {31'h0, wb_io_window},
          {31'h0, inside_range(ea, IO_BASE, IO_BASE + IO_SIZE)});
      chk($sformatf("R4 upper zero vec%0d", i), {16'h0, wb_data[31:16]}, 32'h0);
      if (!ea[0] && !inside_range(ea, IO_BASE, IO_BASE + IO_SIZE)) begin
        chk($sformatf("%s R1 data vec%0d", VECS[i].little ? "R2" : "R3", i),
            wb_data, model_data(ea, VECS[i].little));
      end
    end
  endtask

  task automatic preload(input logic [RAM_AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    pl_we = 1'b1; pl_addr = a; pl_data = d;
    ref_mem[a] = d;
  endtask

  task automatic issue(input logic [31:0] b, input logic [31:0] x, input logic [31:0] g,
                       input logic le, input logic [TAG_W-1:0] t);
    iss_valid = 1'b1; iss_base = b; iss_index = x; iss_guard = g;
    iss_little = le; iss_tag = t;
  endtask

  logic done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    chk("R10 wb_valid in reset", {31'h0, wb_valid}, 32'h0);
    chk("R10 cache_touch in reset", {31'h0, cache_touch}, 32'h0);
    rst = 1'b0;

    // Fill memory through the preload port (R11)
    for (int a = 0; a < MEM_N; a++) begin
      preload(RAM_AW'(a), 8'(a * 37 + (a >> 8)));
    end
    preload(RAM_AW'(32'hD00), 8'h84);
    preload(RAM_AW'(32'hD01), 8'h33);
    preload(RAM_AW'(32'hD02), 8'h22);
    preload(RAM_AW'(32'hD03), 8'h11);
    @(negedge clk);
    pl_we = 1'b0;

    // Table walk, one issue per cycle, results three cycles later
    for (int i = 0; i < NV + 3; i++) begin
      @(negedge clk);
      if (i >= 3) check_vec(i - 3);
      if (i < NV) begin
        issue(VECS[i].base, VECS[i].idx, VECS[i].guard, VECS[i].little, TAG_W'(i));
      end else begin
        iss_valid = 1'b0;
      end
    end

    // Documented values, checked explicitly
    chk("R3 doc value 8433", model_data(32'hD00, 1'b0), 32'h0000_8433);
    chk("R3 doc value 2211", model_data(32'hD02, 1'b0), 32'h0000_2211);

    // Preload overwrite is seen by a later load (R11)
    preload(RAM_AW'(32'h300), 8'h5A);
    preload(RAM_AW'(32'h301), 8'hA5);
    @(negedge clk);
    pl_we = 1'b0;
    issue(32'h300, 32'h0, 32'h1, 1'b1, TAG_W'(20));
    @(negedge clk);
    issue(32'h300, 32'h0, 32'h1, 1'b0, TAG_W'(21));
    @(negedge clk);
    iss_valid = 1'b0;
    @(negedge clk);
    chk("R11 R2 new bytes little", wb_data, 32'h0000_A55A);
    chk("R6 tag 20", 32'(wb_tag), 32'd20);
    @(negedge clk);
    chk("R11 R3 new bytes big", wb_data, 32'h0000_5AA5);
    chk("R6 tag 21", 32'(wb_tag), 32'd21);
    @(negedge clk);
    chk("R6 single result", {31'h0, wb_valid}, 32'h0);

    // Reset while an operation is in flight
    issue(32'hD00, 32'h0, 32'h1, 1'b0, TAG_W'(9));
    @(negedge clk);
    iss_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R10 flushed wb_valid", {31'h0, wb_valid}, 32'h0);
      chk("R10 flushed cache_touch", {31'h0, cache_touch}, 32'h0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule